// File: doc/BRIEF.md
# Single-Clock Queue with Selectable Read Latency

This block is a first-in first-out store for one clock domain. Words enter on a write strobe and leave in arrival order. The width and depth are set by parameters. A parameter picks one of two read styles. In registered-read style, a read strobe fetches the head word, which shows on the output one clock later. In look-ahead style, the head word sits on the output before any strobe, and a read strobe only removes it and brings the next word forward.

Two more parameters set what happens at the edges. When a guard is on, a write into a full queue or a read from an empty queue is refused, and a one-cycle error pulse reports it. When a guard is off, the access goes through. An unguarded write into a full queue replaces the oldest word. An unguarded read from an empty queue in registered-read style shows whatever word sits at the read position.

Top module: `syncq`

## Requirements
- R1: While `rst` is high, and after it falls until the first access, `empty` is 1 and `fillCount`, `full`, `almostFull`, `rdValid`, `overflowErr` and `underflowErr` are 0.
- R2: Words are read back in the order they were written. `fillCount` goes up by one for each accepted write and down by one for each accepted read, so it moves by at most one per cycle.
- R3: With GUARD_OVER=1, a write while `full` is high and no read is accepted is discarded and leaves the contents unchanged. `overflowErr` is then high for exactly the next cycle.
- R4: With GUARD_OVER=0, a write while `full` is high and no read is accepted stores the new word and drops the oldest one. `fillCount` stays at DEPTH and `overflowErr` stays 0.
- R5: `almostFull` is 1 exactly when `fillCount` equals DEPTH-1. `full` is 1 exactly when it equals DEPTH. The two are never high together.
- R6: An accepted read while `full` is high clears `full` after the same edge. A read and a write accepted together, when the queue is neither empty nor full, leave `fillCount` unchanged.
- R7: With GUARD_UNDER=1, a read while `empty` is high changes no stored state and no count. `underflowErr` is then high for exactly the next cycle.
- R8: With GUARD_UNDER=0, a read on an empty queue raises no flag. In registered-read style it sets `rdValid` and shows the word at the current read position, with `fillCount` staying 0. In look-ahead style it has no effect.
- R9: In look-ahead style, a write into an empty queue raises `fillCount` after its own edge. `empty` falls and `rdValid` rises one edge later.
- R10: In look-ahead style, the head word stays on `rdData` while no read is accepted, including while more words are written. An accepted read shows the next word after its edge. A read of the last word sets `empty` and clears `rdValid` in the same update.
- R11: In registered-read style, `rdData` and `rdValid` are updated one edge after an accepted read. `rdValid` is low in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wrReq | input | 1 | Write strobe |
| wrData | input | DATA_W | Word to store |
| rdReq | input | 1 | Read strobe (pop in look-ahead style) |
| rdData | output | DATA_W | Read word, or head word in look-ahead style |
| rdValid | output | 1 | `rdData` holds a valid word |
| full | output | 1 | All DEPTH entries hold words |
| empty | output | 1 | No word is available to read |
| almostFull | output | 1 | Exactly one free entry remains |
| overflowErr | output | 1 | One-cycle pulse after a refused write |
| underflowErr | output | 1 | One-cycle pulse after a refused read |
| fillCount | output | $clog2(DEPTH+1) | Number of stored words |

## Verification
A wrong pointer shows up at `rdData` the first time a word is read back. In look-ahead style this happens at once, because the head word is always on the output. In registered-read style it happens one edge after the read. A wrong count shows up on `fillCount` in the same update, and on `full`, `almostFull` or `empty` when the count reaches a threshold. Because the bench reads back every word it writes, through fill and drain runs of every length up to the depth, a fault in pointer wrap or in dropping the oldest word shows up within one drain.

// File: rtl/syncq_pkg.sv
package syncq_pkg;
  // One-cycle strobes from the control to the datapath.
  typedef struct packed {
    logic write;  // store wrData at the write position
    logic pop;    // advance the read position (accepted read)
    logic drop;   // unguarded write while full: advance past the oldest word
    logic load;   // refresh the output word register
  } strobe_t;
endpackage

// File: rtl/syncq_ctrl.sv
module syncq_ctrl
  import syncq_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter bit FWFT        = 1'b1,
  parameter bit GUARD_OVER  = 1'b1,
  parameter bit GUARD_UNDER = 1'b1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrReq,
  input  logic          rdReq,
  output strobe_t       strb,
  output logic [CW-1:0] fillCount,
  output logic          full,
  output logic          almostFull,
  output logic          empty,
  output logic          rdValid,
  output logic          overflowErr,
  output logic          underflowErr
);
  logic [CW-1:0] countQ, countD;
  logic validQ, validD;
  logic isFull, canRead, grow;
  logic ovfD, unfD;

  always_comb begin
    isFull  = (countQ == CW'(DEPTH));
    canRead = FWFT ? validQ : (countQ != '0);

    strb.pop   = rdReq && canRead;
    strb.drop  = wrReq && isFull && !strb.pop && !GUARD_OVER;
    strb.write = wrReq && (!isFull || strb.pop || !GUARD_OVER);
    grow       = strb.write && !strb.drop;
    countD     = countQ + CW'(grow) - CW'(strb.pop);

    if (FWFT) begin
      // Only words already in storage before this edge may reach the output.
      validD = (countQ > CW'(strb.pop));
    end else begin
      validD = strb.pop || (rdReq && !canRead && !GUARD_UNDER);
    end
    strb.load = validD;

    ovfD = GUARD_OVER && wrReq && isFull && !strb.pop;
    unfD = GUARD_UNDER && rdReq && !canRead;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      countQ       <= '0;
      validQ       <= 1'b0;
      overflowErr  <= 1'b0;
      underflowErr <= 1'b0;
    end else begin
      countQ       <= countD;
      validQ       <= validD;
      overflowErr  <= ovfD;
      underflowErr <= unfD;
    end
  end

  assign fillCount  = countQ;
  assign full       = (countQ == CW'(DEPTH));
  assign almostFull = (countQ == CW'(DEPTH - 1));
  assign rdValid    = validQ;
  assign empty      = FWFT ? !validQ : (countQ == '0);
endmodule

// File: rtl/syncq_dpath.sv
module syncq_dpath
  import syncq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter bit FWFT   = 1'b1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr, rdNext, rdSel;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign rdNext = (strb.pop || strb.drop) ? bump(rdPtr) : rdPtr;

  generate
    if (FWFT) begin : g_ahead
      assign rdSel = rdNext;   // present the word that will be at the head
    end else begin : g_reg
      assign rdSel = rdPtr;    // return the word being read
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strb.write) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (strb.write) wrPtr <= bump(wrPtr);
      rdPtr <= rdNext;
      if (strb.load) rdData <= mem[rdSel];
    end
  end
endmodule

// File: rtl/syncq.sv
module syncq
  import syncq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 4,
  parameter bit FWFT        = 1'b1,
  parameter bit GUARD_OVER  = 1'b1,
  parameter bit GUARD_UNDER = 1'b1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrReq,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdReq,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              full,
  output logic              empty,
  output logic              almostFull,
  output logic              overflowErr,
  output logic              underflowErr,
  output logic [CW-1:0]     fillCount
);
  strobe_t strb;

  syncq_ctrl #(
    .DEPTH(DEPTH), .FWFT(FWFT), .GUARD_OVER(GUARD_OVER), .GUARD_UNDER(GUARD_UNDER)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wrReq(wrReq), .rdReq(rdReq), .strb(strb),
    .fillCount(fillCount), .full(full), .almostFull(almostFull), .empty(empty),
    .rdValid(rdValid), .overflowErr(overflowErr), .underflowErr(underflowErr)
  );

  syncq_dpath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .FWFT(FWFT)
  ) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/syncq_chk.sv
module syncq_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter bit FWFT   = 1'b1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              wrReq,
  input logic              rdReq,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              full,
  input logic              empty,
  input logic              almostFull,
  input logic              overflowErr,
  input logic              underflowErr,
  input logic [CW-1:0]     fillCount
);
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (int'(fillCount) == int'($past(fillCount))) ||
    (int'(fillCount) == int'($past(fillCount)) + 1) ||
    (int'(fillCount) + 1 == int'($past(fillCount))));

  p_ovf_cause_r3: assert property (@(posedge clk) disable iff (rst)
    overflowErr |-> $past(full && wrReq && !rdReq));

  p_full_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (full && wrReq && !rdReq) |=> full);

  p_flag_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(almostFull && full));

  p_unf_cause_r7: assert property (@(posedge clk) disable iff (rst)
    underflowErr |-> $past(rdReq && empty));

  p_ahead_fill_r9: assert property (@(posedge clk) disable iff (rst)
    (FWFT && empty && fillCount != '0) |=> !empty);

  p_ahead_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (FWFT && rdValid && !rdReq && !(full && wrReq)) |=> (rdValid && $stable(rdData)));

  p_reg_valid_r11: assert property (@(posedge clk) disable iff (rst)
    (!FWFT && rdValid) |-> $past(rdReq));
endmodule

bind syncq syncq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .FWFT(FWFT)) u_chk (
  .clk(clk), .rst(rst), .wrReq(wrReq), .rdReq(rdReq), .rdData(rdData),
  .rdValid(rdValid), .full(full), .empty(empty), .almostFull(almostFull),
  .overflowErr(overflowErr), .underflowErr(underflowErr), .fillCount(fillCount)
);

// File: tb/syncq_test.sv
module syncq_test;
  localparam int DW = 8;
  localparam int DP = 4;
  localparam int CW = $clog2(DP + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrReq = 1'b0, rdReq = 1'b0;
  logic [DW-1:0] wrData = '0;

  // index 0: look-ahead guarded, 1: registered guarded,
  // 2: registered unguarded, 3: look-ahead unguarded
  logic [DW-1:0] rdD [4];
  logic [CW-1:0] cnt [4];
  logic vld [4], ful [4], emp [4], alf [4], ovf [4], unf [4];

  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  syncq #(.DATA_W(DW), .DEPTH(DP), .FWFT(1), .GUARD_OVER(1), .GUARD_UNDER(1)) uut (
    .clk(clk), .rst(rst), .wrReq(wrReq), .wrData(wrData), .rdReq(rdReq),
    .rdData(rdD[0]), .rdValid(vld[0]), .full(ful[0]), .empty(emp[0]), .almostFull(alf[0]),
    .overflowErr(ovf[0]), .underflowErr(unf[0]), .fillCount(cnt[0]));
  syncq #(.DATA_W(DW), .DEPTH(DP), .FWFT(0), .GUARD_OVER(1), .GUARD_UNDER(1)) uStdG (
    .clk(clk), .rst(rst), .wrReq(wrReq), .wrData(wrData), .rdReq(rdReq),
    .rdData(rdD[1]), .rdValid(vld[1]), .full(ful[1]), .empty(emp[1]), .almostFull(alf[1]),
    .overflowErr(ovf[1]), .underflowErr(unf[1]), .fillCount(cnt[1]));
  syncq #(.DATA_W(DW), .DEPTH(DP), .FWFT(0), .GUARD_OVER(0), .GUARD_UNDER(0)) uStdO (
    .clk(clk), .rst(rst), .wrReq(wrReq), .wrData(wrData), .rdReq(rdReq),
    .rdData(rdD[2]), .rdValid(vld[2]), .full(ful[2]), .empty(emp[2]), .almostFull(alf[2]),
    .overflowErr(ovf[2]), .underflowErr(unf[2]), .fillCount(cnt[2]));
  syncq #(.DATA_W(DW), .DEPTH(DP), .FWFT(1), .GUARD_OVER(0), .GUARD_UNDER(0)) uAhdO (
    .clk(clk), .rst(rst), .wrReq(wrReq), .wrData(wrData), .rdReq(rdReq),
    .rdData(rdD[3]), .rdValid(vld[3]), .full(ful[3]), .empty(emp[3]), .almostFull(alf[3]),
    .overflowErr(ovf[3]), .underflowErr(unf[3]), .fillCount(cnt[3]));

  task automatic expect_eq(input string req, input int inst, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s inst%0d: actual %0d expected %0d", req, inst, act, exp);
    end
  endtask

  // Drive one cycle of inputs just after an edge; outputs are sampled after the next edge.
  task automatic cyc(input logic w, input int d, input logic r);
    wrReq = w; wrData = DW'(d); rdReq = r;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    for (int k = 0; k < 4; k++) begin
      expect_eq("R1 empty", k, emp[k], 1);
      expect_eq("R1 count", k, cnt[k], 0);
      expect_eq("R1 flags", k, {ful[k], alf[k], vld[k], ovf[k], unf[k]}, 0);
    end
    rst = 1'b0;
    cyc(0, 0, 0);
    for (int k = 0; k < 4; k++) expect_eq("R1 idle", k, {emp[k], vld[k]}, 2);

    // Fill with 1..4
    cyc(1, 1, 0);
    for (int k = 0; k < 4; k++) expect_eq("R9 count first", k, cnt[k], 1);
    expect_eq("R9 empty lag", 0, emp[0], 1);
    expect_eq("R9 empty lag", 3, emp[3], 1);
    expect_eq("R11 std empty", 1, emp[1], 0);
    cyc(1, 2, 0);
    for (int k = 0; k < 4; k += 3) begin
      expect_eq("R9 valid", k, vld[k], 1);
      expect_eq("R9 empty", k, emp[k], 0);
      expect_eq("R10 head", k, rdD[k], 1);
    end
    expect_eq("R11 no read", 1, vld[1], 0);
    cyc(1, 3, 0);
    for (int k = 0; k < 4; k++) expect_eq("R5 almost", k, {alf[k], ful[k]}, 2);
    expect_eq("R10 hold", 0, rdD[0], 1);
    cyc(1, 4, 0);
    for (int k = 0; k < 4; k++) expect_eq("R5 full", k, {alf[k], ful[k], 3'(cnt[k])}, 12);

    // Write while full
    cyc(1, 5, 0);
    expect_eq("R3 pulse", 0, ovf[0], 1);
    expect_eq("R3 pulse", 1, ovf[1], 1);
    expect_eq("R4 no flag", 2, ovf[2], 0);
    expect_eq("R4 no flag", 3, ovf[3], 0);
    for (int k = 0; k < 4; k++) expect_eq("R3 R4 count", k, cnt[k], 4);
    expect_eq("R3 head kept", 0, rdD[0], 1);
    expect_eq("R4 oldest dropped", 3, rdD[3], 2);
    cyc(0, 0, 0);
    expect_eq("R3 single pulse", 0, ovf[0], 0);
    expect_eq("R3 single pulse", 1, ovf[1], 0);

    // Read while full, then simultaneous read and write
    cyc(0, 0, 1);
    for (int k = 0; k < 4; k++) expect_eq("R6 full clears", k, {ful[k], 3'(cnt[k])}, 3);
    expect_eq("R10 next", 0, rdD[0], 2);
    expect_eq("R11 data", 1, {vld[1], rdD[1]}, 256 + 1);
    expect_eq("R4 data", 2, rdD[2], 2);
    expect_eq("R4 next", 3, rdD[3], 3);
    cyc(1, 6, 1);
    for (int k = 0; k < 4; k++) expect_eq("R6 count steady", k, cnt[k], 3);
    expect_eq("R10 next", 0, rdD[0], 3);
    expect_eq("R2 data", 1, rdD[1], 2);
    expect_eq("R4 data", 2, rdD[2], 3);
    expect_eq("R4 next", 3, rdD[3], 4);

    // Drain
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 1);
      expect_eq("R2 std g", 1, rdD[1], (i == 0) ? 3 : (i == 1) ? 4 : 6);
      expect_eq("R4 std o", 2, rdD[2], 4 + i);
      if (i < 2) begin
        expect_eq("R10 ahead g", 0, rdD[0], (i == 0) ? 4 : 6);
        expect_eq("R4 ahead o", 3, rdD[3], 5 + i);
      end else begin
        expect_eq("R10 last", 0, {emp[0], vld[0]}, 2);
        expect_eq("R10 last", 3, {emp[3], vld[3]}, 2);
      end
    end

    // Read while empty
    cyc(0, 0, 1);
    expect_eq("R7 pulse", 0, unf[0], 1);
    expect_eq("R7 pulse", 1, {unf[1], vld[1]}, 2);
    expect_eq("R8 stale read", 2, {unf[2], vld[2], rdD[2]}, 256 + 3);
    expect_eq("R8 no effect", 3, {unf[3], vld[3], emp[3]}, 1);
    for (int k = 0; k < 4; k++) expect_eq("R7 R8 count", k, cnt[k], 0);
    cyc(0, 0, 0);
    expect_eq("R7 single pulse", 0, unf[0], 0);
    expect_eq("R7 single pulse", 1, unf[1], 0);
    expect_eq("R11 valid low", 2, vld[2], 0);

    // Sweep: fill n words then drain, every length
    for (int n = 1; n <= DP; n++) begin
      for (int i = 0; i < n; i++) cyc(1, 16 * n + i, 0);
      cyc(0, 0, 0);
      for (int k = 0; k < 4; k++) expect_eq("R2 fill count", k, cnt[k], n);
      for (int i = 0; i < n; i++) begin
        expect_eq("R10 sweep head", 0, {vld[0], rdD[0]}, 256 + 16 * n + i);
        expect_eq("R10 sweep head", 3, {vld[3], rdD[3]}, 256 + 16 * n + i);
        cyc(0, 0, 1);
        expect_eq("R11 sweep", 1, {vld[1], rdD[1]}, 256 + 16 * n + i);
        expect_eq("R11 sweep", 2, {vld[2], rdD[2]}, 256 + 16 * n + i);
      end
      for (int k = 0; k < 4; k++) expect_eq("R2 drained", k, {emp[k], 3'(cnt[k])}, 8);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule